// File: doc/BRIEF.md
# DMA Transfer Chunk Sequencer

This block accepts one DMA job at a time and cuts it into a series of bounded bursts for a downstream transfer engine. A job carries a direction, an even byte start address, a total length in 16-bit words and a per-job burst limit. The sequencer issues one chunk command at a time. Each command carries the chunk's byte address and word count. It also carries the word offset of that chunk within the host buffer, which equals the number of words already moved by earlier chunks.

After each chunk the engine returns a response marked either done or timed out. A clean response moves the job on to the next chunk. A timeout ends the job at once as failed. When the job ends, a one-cycle completion pulse appears together with a success flag. A job of zero words completes with success and issues no chunk. A job with an odd start address completes as failed and issues no chunk.

Top module: `dma_chunk_seq`

## Requirements
- R1: After reset `job_ready` is 1 and `cmd_valid` and `job_done` are 0. `job_ready` is 1 only while the block is idle, and a job is taken on a clock edge where `job_valid` and `job_ready` are both 1.
- R2: The effective burst limit is `job_limit` when that value is in 1..512. A `job_limit` of 0 or above 512 is treated as 512.
- R3: Each chunk's `cmd_words` is the smaller of the effective limit and the words still outstanding. It is never 0 and never above 512, and a successful job issues exactly ceil(words / limit) chunks.
- R4: The first chunk's `cmd_addr` is the job start address. Each later chunk starts at the previous chunk address plus 2 × the previous chunk word count, modulo 2^18.
- R5: `cmd_buf_off` and `cmd_done_words` both equal (`cmd_addr` − job start address) / 2.
- R6: `cmd_dir` (0 = read, 1 = write) equals the job's `job_dir` on every chunk of that job.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command and all of its fields stay unchanged.
- R8: A response with `rsp_timeout` = 1 ends the job. On the next cycle `job_done` = 1 with `job_ok` = 0, and no further chunk is issued.
- R9: Once the last chunk's response arrives without a timeout, `job_done` pulses for exactly one cycle with `job_ok` = 1, and the block then returns to idle.
- R10: A job with `job_words` = 0 gives `job_done` = 1 with `job_ok` = 1 on the cycle after acceptance and issues no chunk.
- R11: A job whose `job_addr` bit 0 is 1 gives `job_done` = 1 with `job_ok` = 0 on the cycle after acceptance and issues no chunk.
- R12: `rsp_valid` is ignored unless the block is waiting for a chunk response. A stray response during a stalled command neither alters the command nor ends the job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| job_valid | input | 1 | New job offered |
| job_ready | output | 1 | Block idle, job can be taken |
| job_dir | input | 1 | Direction: 0 read, 1 write |
| job_addr | input | 18 | Start byte address |
| job_words | input | 17 | Total words in the job |
| job_limit | input | 10 | Burst limit in words (0 or >512 means 512) |
| cmd_valid | output | 1 | Chunk command present |
| cmd_ready | input | 1 | Engine takes the chunk command |
| cmd_dir | output | 1 | Chunk direction |
| cmd_addr | output | 18 | Chunk start byte address |
| cmd_words | output | 10 | Chunk word count |
| cmd_buf_off | output | 17 | Word offset of chunk in host buffer |
| cmd_done_words | output | 17 | Words finished by earlier chunks |
| rsp_valid | input | 1 | Engine reports chunk end |
| rsp_timeout | input | 1 | Chunk ended in a bus timeout |
| job_done | output | 1 | One-cycle job completion pulse |
| job_ok | output | 1 | Job success, valid with `job_done` |

## Verification
The hardest case to reach is a stray response arriving while a chunk command is held back by the engine. That is the only point where an ignored response could corrupt the address or end the job early. The bench reaches it by lowering `cmd_ready` for a cycle on selected chunks of a sweep and pulsing a timed-out response during that stall. It then confirms that the same command is still offered and that the job finishes normally. Timeouts are also injected on each chunk index of a multi-chunk job in turn, so that the abort path is seen from the first, middle and last chunk.

// File: rtl/dma_chunk_pkg.sv
package dma_chunk_pkg;
    localparam int ADDR_W    = 18;
    localparam int MAX_CHUNK = 512;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_chunk_limit.sv
module dma_chunk_limit #(
    parameter int MAX_CHUNK = 512,
    parameter int LIM_W     = $clog2(MAX_CHUNK) + 1
) (
    input  logic [LIM_W-1:0] lim_raw,
    output logic [LIM_W-1:0] lim_eff
);
    localparam logic [LIM_W-1:0] MAX_V = LIM_W'(MAX_CHUNK);

    always_comb begin
        if (lim_raw == '0 || lim_raw > MAX_V)
            lim_eff = MAX_V;
        else
            lim_eff = lim_raw;
    end
endmodule

// File: rtl/dma_chunk_sizer.sv
module dma_chunk_sizer #(
    parameter int CNT_W = 17,
    parameter int LIM_W = 10
) (
    input  logic [CNT_W-1:0] remain,
    input  logic [LIM_W-1:0] limit,
    output logic [LIM_W-1:0] words
);
    always_comb begin
        if (remain < CNT_W'(limit))
            words = remain[LIM_W-1:0];
        else
            words = limit;
    end
endmodule

// File: rtl/dma_chunk_offset.sv
module dma_chunk_offset #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = ADDR_W - 1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] cur,
    output logic [CNT_W-1:0]  word_off
);
    logic [ADDR_W-1:0] byte_diff;

    always_comb begin
        byte_diff = cur - base;
        word_off  = CNT_W'(byte_diff >> 1);
    end
endmodule

// File: rtl/dma_chunk_seq.sv
module dma_chunk_seq
    import dma_chunk_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int MAXC   = MAX_CHUNK,
    parameter int LW     = $clog2(MAXC) + 1,
    parameter int CW     = AW - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          job_valid,
    output logic          job_ready,
    input  logic          job_dir,
    input  logic [AW-1:0] job_addr,
    input  logic [CW-1:0] job_words,
    input  logic [LW-1:0] job_limit,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic          cmd_dir,
    output logic [AW-1:0] cmd_addr,
    output logic [LW-1:0] cmd_words,
    output logic [CW-1:0] cmd_buf_off,
    output logic [CW-1:0] cmd_done_words,
    input  logic          rsp_valid,
    input  logic          rsp_timeout,
    output logic          job_done,
    output logic          job_ok
);
    typedef struct packed {
        seq_state_e    st;
        logic          dir;
        logic [AW-1:0] base;
        logic [AW-1:0] addr;
        logic [CW-1:0] rem;
        logic [LW-1:0] lim;
        logic          ok;
    } seq_regs_t;

    seq_regs_t     r_d, r_q;
    logic [LW-1:0] lim_eff_d;
    logic [LW-1:0] cur_words_d;
    logic [CW-1:0] word_off_d;

    dma_chunk_limit #(.MAX_CHUNK(MAXC), .LIM_W(LW)) u_limit (
        .lim_raw (job_limit),
        .lim_eff (lim_eff_d)
    );

    dma_chunk_sizer #(.CNT_W(CW), .LIM_W(LW)) u_sizer (
        .remain (r_q.rem),
        .limit  (r_q.lim),
        .words  (cur_words_d)
    );

    dma_chunk_offset #(.ADDR_W(AW), .CNT_W(CW)) u_offset (
        .base     (r_q.base),
        .cur      (r_q.addr),
        .word_off (word_off_d)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (job_valid) begin
                    r_d.dir  = job_dir;
                    r_d.base = job_addr;
                    r_d.addr = job_addr;
                    r_d.rem  = job_words;
                    r_d.lim  = lim_eff_d;
                    if (job_words == '0) begin
                        r_d.st = ST_DONE;
                        r_d.ok = 1'b1;
                    end else if (job_addr[0]) begin
                        r_d.st = ST_DONE;
                        r_d.ok = 1'b0;
                    end else begin
                        r_d.st = ST_ISSUE;
                        r_d.ok = 1'b1;
                    end
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_timeout) begin
                        r_d.st = ST_DONE;
                        r_d.ok = 1'b0;
                    end else begin
                        r_d.addr = r_q.addr + AW'({cur_words_d, 1'b0});
                        r_d.rem  = r_q.rem - CW'(cur_words_d);
                        r_d.st   = (r_q.rem == CW'(cur_words_d)) ? ST_DONE : ST_ISSUE;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, dir: 1'b0, base: '0, addr: '0,
                     rem: '0, lim: '0, ok: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign job_ready      = (r_q.st == ST_IDLE);
    assign cmd_valid      = (r_q.st == ST_ISSUE);
    assign job_done       = (r_q.st == ST_DONE);
    assign job_ok         = r_q.ok;
    assign cmd_dir        = r_q.dir;
    assign cmd_addr       = r_q.addr;
    assign cmd_words      = cur_words_d;
    assign cmd_buf_off    = word_off_d;
    assign cmd_done_words = word_off_d;

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr)
                                    && $stable(cmd_words) && $stable(cmd_dir));

    // R3
    chunk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_words != '0) && (cmd_words <= LW'(MAXC)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> !job_done && job_ready);

    // R1
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_ready |-> !cmd_valid && !job_done);

    // R4
    addr_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !cmd_addr[0]);

    // R8
    timeout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !job_ready && !cmd_valid && !job_done && rsp_valid && rsp_timeout
        |=> job_done && !job_ok);
endmodule

// File: tb/dma_chunk_seq_tb.sv
module dma_chunk_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        job_valid = 1'b0;
    logic        job_ready;
    logic        job_dir = 1'b0;
    logic [17:0] job_addr = '0;
    logic [16:0] job_words = '0;
    logic [9:0]  job_limit = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic        cmd_dir;
    logic [17:0] cmd_addr;
    logic [9:0]  cmd_words;
    logic [16:0] cmd_buf_off;
    logic [16:0] cmd_done_words;
    logic        rsp_valid = 1'b0;
    logic        rsp_timeout = 1'b0;
    logic        job_done;
    logic        job_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_chunk_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .job_valid(job_valid), .job_ready(job_ready), .job_dir(job_dir),
        .job_addr(job_addr), .job_words(job_words), .job_limit(job_limit),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_dir(cmd_dir),
        .cmd_addr(cmd_addr), .cmd_words(cmd_words), .cmd_buf_off(cmd_buf_off),
        .cmd_done_words(cmd_done_words), .rsp_valid(rsp_valid),
        .rsp_timeout(rsp_timeout), .job_done(job_done), .job_ok(job_ok)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_job(input bit dir, input int addr, input int words,
                           input int limit, input int to_at, input bit stall);
        int eff, rem, ca, i, w, nchunks;
        eff = (limit == 0 || limit > 512) ? 512 : limit;
        chk("R1 ready before job", job_ready, 1);
        job_valid = 1'b1;
        job_dir   = dir;
        job_addr  = 18'(addr);
        job_words = 17'(words);
        job_limit = 10'(limit);
        step();
        job_valid = 1'b0;
        if (words == 0) begin
            chk("R10 done", job_done, 1);
            chk("R10 ok", job_ok, 1);
            chk("R10 no chunk", cmd_valid, 0);
        end else if (addr % 2 == 1) begin
            chk("R11 done", job_done, 1);
            chk("R11 ok", job_ok, 0);
            chk("R11 no chunk", cmd_valid, 0);
        end else begin
            rem = words;
            ca  = addr;
            i   = 0;
            nchunks = (words + eff - 1) / eff;
            forever begin
                w = (rem < eff) ? rem : eff;
                chk("R3 cmd_valid", cmd_valid, 1);
                chk("R1 busy not ready", job_ready, 0);
                chk("R4 cmd_addr", cmd_addr, ca % 262144);
                chk("R2 R3 cmd_words", cmd_words, w);
                chk("R5 buf_off", cmd_buf_off, ((ca - addr) % 262144) / 2);
                chk("R5 done_words", cmd_done_words, ((ca - addr) % 262144) / 2);
                chk("R6 cmd_dir", cmd_dir, dir);
                if (stall && (i % 2 == 0)) begin
                    rsp_valid   = 1'b1;
                    rsp_timeout = 1'b1;
                    step();
                    rsp_valid   = 1'b0;
                    rsp_timeout = 1'b0;
                    chk("R7 R12 held valid", cmd_valid, 1);
                    chk("R7 R12 held addr", cmd_addr, ca % 262144);
                    chk("R7 held words", cmd_words, w);
                    chk("R12 no done", job_done, 0);
                end
                cmd_ready = 1'b1;
                step();
                cmd_ready = 1'b0;
                chk("R3 cmd taken", cmd_valid, 0);
                if (stall) step();
                rsp_valid   = 1'b1;
                rsp_timeout = (i == to_at);
                step();
                rsp_valid   = 1'b0;
                rsp_timeout = 1'b0;
                if (i == to_at) begin
                    chk("R8 done", job_done, 1);
                    chk("R8 ok", job_ok, 0);
                    chk("R8 no chunk", cmd_valid, 0);
                    break;
                end
                rem -= w;
                ca  += 2 * w;
                i++;
                if (rem == 0) begin
                    chk("R9 done", job_done, 1);
                    chk("R9 ok", job_ok, 1);
                    chk("R3 chunk count", i, nchunks);
                    break;
                end
            end
        end
        step();
        chk("R9 single pulse", job_done, 0);
        chk("R1 idle again", job_ready, 1);
        chk("R8 no more chunks", cmd_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", job_ready, 1);
        chk("R1 reset cmd_valid", cmd_valid, 0);
        chk("R1 reset done", job_done, 0);
        rst_n = 1'b1;
        step();
        chk("R1 post reset ready", job_ready, 1);

        for (int wd = 0; wd <= 12; wd++)
            for (int lm = 1; lm <= 5; lm++)
                run_job(bit'((wd + lm) % 2), 256 + 2 * wd * lm, wd, lm, -1,
                        bit'((wd + lm) % 3 == 0));

        for (int t = 0; t < 4; t++)
            run_job(1'b1, 4096, 7, 2, t, 1'b0);

        run_job(1'b0, 1000, 1100, 0, -1, 1'b0);
        run_job(1'b1, 2000, 1100, 513, -1, 1'b1);
        run_job(1'b0, 3000, 1100, 1023, -1, 1'b0);
        run_job(1'b1, 10, 512, 512, -1, 1'b0);
        run_job(1'b0, 12, 513, 512, 1, 1'b0);
        run_job(1'b1, 262128, 8, 3, -1, 1'b0);
        run_job(1'b0, 77, 5, 2, -1, 1'b0);
        run_job(1'b1, 1, 0, 2, -1, 1'b0);
        run_job(1'b0, 262143, 300, 0, -1, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule